// File: doc/BRIEF.md
# Test Pin Selector with Divider Bypass

This block picks what a single observation pin shows. A 3-bit select code chooses the source. The sources are the serial shift chain output, a constant high or low level, the reference clock, the loop-counter terminal pulse, the output clock, and the output clock divided by four. One code has a second effect: it puts the block in bypass. In bypass, the serial clock takes over from the oscillator clock as the count source for the loop counter and the output divider. The pin then shows the loop-counter pulse.

Everything runs on one fast sampling clock, `clk`. The oscillator clock and the serial clock arrive as one-cycle tick strobes. The reference clock and the output clock arrive as sampled levels. The block contains a programmable modulo-M counter fed by the selected tick. When the count source changes, a handover stage blocks all ticks for a fixed number of cycles. No tick can then be lost in a way that shortens a period, and none can be counted twice. The `src_is_ser` output tells the downstream output divider which tick to use. A low parallel-load strobe holds the select register at code 0.

Top module: `test_mux_bypass`

## Requirements
- R1: Select code 3'b000 places `shreg_out` on `test_pin`.
- R2: Code 3'b001 holds `test_pin` at 1 and code 3'b101 holds it at 0.
- R3: Code 3'b010 copies `ref_clk` to `test_pin` and code 3'b100 copies `out_clk` to `test_pin`.
- R4: Code 3'b111 shows the output clock divided by four. A 2-bit counter cleared by reset advances on each 0-to-1 change of `out_clk`, and the pin shows its upper bit. After 1, 2, 3 and 4 rising edges the pin reads 0, 1, 1 and 0.
- R5: Code 3'b011 shows the loop-counter terminal pulse. The counter counts down from M-1 to 0 on each oscillator tick, reloading after terminal count. A pulse is one `clk` cycle wide, and pulses are M ticks apart.
- R6: An `m_val` of 0 or 1 divides by one, so every selected tick produces a pulse.
- R7: While `par_load` is 0, the select register is held at code 3'b000 and `test_pin` follows `shreg_out` whatever `t_code` is.
- R8: Code 3'b110 selects bypass. `src_is_ser` goes to 1, the loop counter counts `ser_tick` instead of `vco_tick`, and `test_pin` shows the loop-counter pulse. Oscillator ticks then produce no pulses. Outside bypass, serial ticks produce none.
- R9: When the wanted source differs from the current one, ticks are blocked for GAP_CYC cycles before `src_is_ser` changes. With the default GAP_CYC of 2, `src_is_ser` changes on the fourth `clk` edge after `t_code` is presented, and not earlier.
- R10: After reset, `test_pin` is 0 and `src_is_ser` is 0. The loop counter sits at terminal count, so the first selected tick produces a pulse.
- R11: A new static selection reaches `test_pin` on the second `clk` edge after `t_code` is presented: one edge for the select register, one for the pin register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Asynchronous reset, active high |
| vco_tick | input | 1 | One-cycle strobe per oscillator clock period |
| ser_tick | input | 1 | One-cycle strobe per serial clock rising edge |
| ref_clk | input | 1 | Sampled reference clock level |
| out_clk | input | 1 | Sampled divided output clock level |
| shreg_out | input | 1 | Serial shift chain output |
| m_val | input | MW (7) | Loop counter modulus |
| t_code | input | 3 | Observation select code |
| par_load | input | 1 | Parallel load strobe; 0 holds the select at code 0 |
| test_pin | output | 1 | Observation pin, registered |
| src_is_ser | output | 1 | 1 when the dividers count serial ticks |

## Verification
The bench measures the spacing and width of the terminal pulse for a mid-range modulus, for the upper limit of 80, and for moduli 0 and 1. A counter that reloads with M instead of M-1 would stretch the period by one tick. A counter that mishandles small moduli would stall and never pulse. It also feeds ticks from only the unselected source, in and out of bypass, and expects a silent pin. A design that ignored `src_is_ser` would show pulses there. It samples `src_is_ser` one cycle before and at the expected switch cycle, which exposes a handover that is too fast or too slow. It also drives `t_code` with `par_load` low, which catches a select register that escapes the forced code.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [2:0] {
    TS_SHIFT     = 3'd0,
    TS_HIGH      = 3'd1,
    TS_REF       = 3'd2,
    TS_MCNT      = 3'd3,
    TS_FOUT      = 3'd4,
    TS_LOW       = 3'd5,
    TS_BYPASS    = 3'd6,
    TS_FOUT_DIV4 = 3'd7
  } tsel_e;

  typedef enum logic {
    SW_RUN  = 1'b0,
    SW_HOLD = 1'b1
  } sw_state_e;
endpackage

// File: rtl/tsel_latch.sv
module tsel_latch
  import tsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       par_load,
  input  logic [2:0] t_code,
  output tsel_e      sel_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)            sel_q <= TS_SHIFT;
    else if (!par_load) sel_q <= TS_SHIFT;
    else                sel_q <= tsel_e'(t_code);
  end

  AST_PLOAD_FORCES_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !par_load |=> sel_q == TS_SHIFT); // R7
endmodule

// File: rtl/src_switch.sv
module src_switch
  import tsel_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic want_ser,
  input  logic vco_tick,
  input  logic ser_tick,
  output logic use_ser,
  output logic div_tick
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  sw_state_e      state;
  logic [GW-1:0]  gap_cnt;
  logic           target;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= SW_RUN;
      gap_cnt <= '0;
      target  <= 1'b0;
      use_ser <= 1'b0;
    end else begin
      case (state)
        SW_RUN: begin
          if (want_ser != use_ser) begin
            state   <= SW_HOLD;
            target  <= want_ser;
            gap_cnt <= GW'(GAP_CYC - 1);
          end
        end
        default: begin
          if (gap_cnt == '0) begin
            use_ser <= target;
            state   <= SW_RUN;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    div_tick = 1'b0;
    if (state == SW_RUN) div_tick = use_ser ? ser_tick : vco_tick;
  end

  AST_SWITCH_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (use_ser != $past(use_ser)) |-> $past(state) == SW_HOLD); // R9
endmodule

// File: rtl/mod_m_count.sv
module mod_m_count #(
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [MW-1:0] m_val,
  output logic          term
);
  logic [MW-1:0] cnt;
  logic [MW-1:0] reload;

  always_comb begin
    if (m_val < MW'(2)) reload = '0;
    else                reload = m_val - 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt  <= '0;
      term <= 1'b0;
    end else if (tick) begin
      if (cnt == '0) begin
        cnt  <= reload;
        term <= 1'b1;
      end else begin
        cnt  <= cnt - 1'b1;
        term <= 1'b0;
      end
    end else begin
      term <= 1'b0;
    end
  end

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    term |-> $past(tick)); // R5
endmodule

// File: rtl/edge_div.sv
module edge_div #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic q
);
  logic                prev;
  logic [DIV_LOG2-1:0] cnt;
  logic                rise;

  assign rise = lvl & ~prev;
  assign q    = cnt[DIV_LOG2-1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= lvl;
      if (rise) cnt <= cnt + 1'b1;
    end
  end

  AST_DIV_STEPS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> $past(rise)); // R4
endmodule

// File: rtl/test_mux_bypass.sv
module test_mux_bypass
  import tsel_pkg::*;
#(
  parameter int MW      = 7,
  parameter int GAP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vco_tick,
  input  logic          ser_tick,
  input  logic          ref_clk,
  input  logic          out_clk,
  input  logic          shreg_out,
  input  logic [MW-1:0] m_val,
  input  logic [2:0]    t_code,
  input  logic          par_load,
  output logic          test_pin,
  output logic          src_is_ser
);
  tsel_e sel_q;
  logic  div_tick;
  logic  term;
  logic  div4_q;
  logic  want_ser;

  tsel_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .par_load (par_load),
    .t_code   (t_code),
    .sel_q    (sel_q)
  );

  assign want_ser = (sel_q == TS_BYPASS);

  src_switch #(.GAP_CYC(GAP_CYC)) u_switch (
    .clk      (clk),
    .rst      (rst),
    .want_ser (want_ser),
    .vco_tick (vco_tick),
    .ser_tick (ser_tick),
    .use_ser  (src_is_ser),
    .div_tick (div_tick)
  );

  mod_m_count #(.MW(MW)) u_mcount (
    .clk   (clk),
    .rst   (rst),
    .tick  (div_tick),
    .m_val (m_val),
    .term  (term)
  );

  edge_div #(.DIV_LOG2(2)) u_div4 (
    .clk (clk),
    .rst (rst),
    .lvl (out_clk),
    .q   (div4_q)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      test_pin <= 1'b0;
    end else begin
      case (sel_q)
        TS_SHIFT:     test_pin <= shreg_out;
        TS_HIGH:      test_pin <= 1'b1;
        TS_REF:       test_pin <= ref_clk;
        TS_MCNT:      test_pin <= term;
        TS_FOUT:      test_pin <= out_clk;
        TS_LOW:       test_pin <= 1'b0;
        TS_BYPASS:    test_pin <= term;
        default:      test_pin <= div4_q;
      endcase
    end
  end

  AST_PLOAD_PIN_FOLLOWS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!par_load && $past(!par_load)) |=> test_pin == $past(shreg_out)); // R7
endmodule

// File: tb/test_test_mux_bypass.sv
module test_test_mux_bypass;
  logic       clk = 1'b0;
  logic       rst;
  logic       vco_tick, ser_tick, ref_clk, out_clk, shreg_out, par_load;
  logic [6:0] m_val;
  logic [2:0] t_code;
  logic       test_pin, src_is_ser;

  logic vco_en = 1'b0, ser_en = 1'b0, tgl = 1'b0;
  int   total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tgl      <= ~tgl;
    vco_tick <= vco_en & tgl;
    ser_tick <= ser_en & tgl;
  end

  test_mux_bypass i_test_mux_bypass (
    .clk(clk), .rst(rst), .vco_tick(vco_tick), .ser_tick(ser_tick),
    .ref_clk(ref_clk), .out_clk(out_clk), .shreg_out(shreg_out),
    .m_val(m_val), .t_code(t_code), .par_load(par_load),
    .test_pin(test_pin), .src_is_ser(src_is_ser)
  );

  // {t_code[2:0], par_load, shreg_out, level on ref/out clock, expected pin}
  localparam logic [6:0] VEC [11] = '{
    {3'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd5, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd4, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd5, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b exp=%0b at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string req);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; vco_en = 1'b0; ser_en = 1'b0;
    ref_clk = 1'b0; out_clk = 1'b0; shreg_out = 1'b0;
    m_val = 7'd5; t_code = 3'd0; par_load = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // rising-edge spacing and high width of test_pin, sampled at negedges
  task automatic measure(output int gap, output int width);
    int t1, lim;
    gap = -1; width = 0; lim = 0;
    while (test_pin !== 1'b0 && lim < 400) begin @(negedge clk); lim++; end
    while (test_pin !== 1'b1 && lim < 400) begin @(negedge clk); lim++; end
    t1 = cyc;
    while (test_pin === 1'b1 && lim < 400) begin width++; @(negedge clk); lim++; end
    while (test_pin !== 1'b1 && lim < 400) begin @(negedge clk); lim++; end
    if (lim < 400) gap = cyc - t1;
  endtask

  task automatic count_high(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (test_pin === 1'b1) hits++;
    end
  endtask

  task automatic out_rise();
    out_clk = 1'b1; repeat (3) @(negedge clk);
    out_clk = 1'b0; repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap, width, hits;
    string req;

    rst = 1'b1; vco_tick = 1'b0; ser_tick = 1'b0;
    ref_clk = 1'b0; out_clk = 1'b0; shreg_out = 1'b1;
    m_val = 7'd5; t_code = 3'd1; par_load = 1'b1;
    @(negedge clk);
    check(test_pin, 1'b0, "R10 reset pin");
    check(src_is_ser, 1'b0, "R10 reset source");
    do_reset();

    for (int v = 0; v < 11; v++) begin
      t_code = VEC[v][6:4]; par_load = VEC[v][3]; shreg_out = VEC[v][2];
      ref_clk = VEC[v][1]; out_clk = VEC[v][1];
      repeat (3) @(negedge clk);
      if (!VEC[v][3])                              req = "R7";
      else if (VEC[v][6:4] == 3'd0)                req = "R1";
      else if (VEC[v][6:4] == 3'd1 || VEC[v][6:4] == 3'd5) req = "R2";
      else                                         req = "R3";
      check(test_pin, VEC[v][0], $sformatf("%s vector %0d", req, v));
    end
    par_load = 1'b1;

    // R11: two-edge latency
    t_code = 3'd5; repeat (3) @(negedge clk);
    t_code = 3'd1;
    @(negedge clk); check(test_pin, 1'b0, "R11 after one edge");
    @(negedge clk); check(test_pin, 1'b1, "R11 after two edges");

    // R4: divide by four
    do_reset();
    t_code = 3'd7; repeat (3) @(negedge clk);
    check(test_pin, 1'b0, "R4 no edges");
    out_rise(); check(test_pin, 1'b0, "R4 one edge");
    out_rise(); check(test_pin, 1'b1, "R4 two edges");
    out_rise(); check(test_pin, 1'b1, "R4 three edges");
    out_rise(); check(test_pin, 1'b0, "R4 four edges");

    // R10: first tick after reset pulses
    do_reset();
    t_code = 3'd3; m_val = 7'd9; repeat (3) @(negedge clk);
    vco_en = 1'b1;
    count_high(6, hits);
    check_int(hits, 1, "R10 first tick pulses");

    // R5: modulus spacing and width
    m_val = 7'd5; repeat (24) @(negedge clk);
    measure(gap, width);
    check_int(gap, 10, "R5 spacing M=5");
    check_int(width, 1, "R5 width M=5");
    m_val = 7'd80; repeat (340) @(negedge clk);
    measure(gap, width);
    check_int(gap, 160, "R5 spacing M=80");

    // R6: modulus 0 and 1
    m_val = 7'd1; repeat (340) @(negedge clk);
    measure(gap, width);
    check_int(gap, 2, "R6 spacing M=1");
    check_int(width, 1, "R6 width M=1");
    m_val = 7'd0; repeat (4) @(negedge clk);
    measure(gap, width);
    check_int(gap, 2, "R6 spacing M=0");

    // R8: serial ticks ignored outside bypass
    vco_en = 1'b0; ser_en = 1'b1; m_val = 7'd3;
    repeat (6) @(negedge clk);
    count_high(40, hits);
    check_int(hits, 0, "R8 serial ignored in code 3");

    // R9: handover timing
    t_code = 3'd6;
    repeat (3) @(negedge clk);
    check(src_is_ser, 1'b0, "R9 still oscillator");
    @(negedge clk);
    check(src_is_ser, 1'b1, "R9 serial after gap");

    // R8: bypass counts serial ticks
    repeat (8) @(negedge clk);
    measure(gap, width);
    check_int(gap, 6, "R8 bypass spacing M=3");
    check_int(width, 1, "R8 bypass width");
    ser_en = 1'b0; vco_en = 1'b1;
    repeat (4) @(negedge clk);
    count_high(40, hits);
    check_int(hits, 0, "R8 oscillator ignored in bypass");

    // R9: back to oscillator
    t_code = 3'd3;
    repeat (3) @(negedge clk);
    check(src_is_ser, 1'b1, "R9 still serial");
    @(negedge clk);
    check(src_is_ser, 1'b0, "R9 oscillator after gap");

    // R7: strobe low overrides bypass
    t_code = 3'd6; par_load = 1'b0; shreg_out = 1'b1;
    repeat (8) @(negedge clk);
    check(src_is_ser, 1'b0, "R7 no bypass while strobe low");
    check(test_pin, 1'b1, "R7 shift output shown");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule